// File: doc/BRIEF.md
# Windowed Auxiliary Address Translator

This block sits between a secondary 8-bit processor and a shared system bus. Every 16-bit address the processor issues is sorted into a region. The block then produces one of three things: a 20-bit bus memory address with a memory strobe, a main I/O select, or a secondary I/O select. Two 16 KB windows and two 4 KB windows can each be moved anywhere in the 1 MB bus memory space. Each of these windows takes its upper address bits from its own page register.

The four page registers are loaded through a small write-only register port. A write takes effect on the clock edge that accepts it. Translation itself is purely combinational from the processor address and the current page contents.

The I/O windows do not move. Each one repeats every 2 KB inside its 4 KB slot. The band from 0x8000 to 0xBFFF is unused: an access there raises a flag and drives no select.

Top module: `aux_window_xlate`

## Requirements
- R1: A processor address in 0x0000-0x3FFF asserts mem_sel and drives bus_addr = {low-window page[7:2], cpu_addr[13:0]}. This page is held at register offset 0.
- R2: A processor address in 0xC000-0xFFFF asserts mem_sel and drives bus_addr = {high-window page[7:2], cpu_addr[13:0]}. This page is held at register offset 1.
- R3: A processor address in 0x4000-0x4FFF asserts mem_sel and drives bus_addr = {page at offset 2, cpu_addr[11:0]}.
- R4: A processor address in 0x5000-0x5FFF asserts mem_sel and drives bus_addr = {page at offset 3, cpu_addr[11:0]}.
- R5: A processor address in 0x7000-0x7FFF asserts io_main_sel and drives bus_addr = {9'b0, cpu_addr[10:0]}. As a result, 0x7xxx and 0x7xxx+0x800 give the same bus address.
- R6: A processor address in 0x6000-0x6FFF asserts io_sec_sel and drives bus_addr = {9'b0, cpu_addr[10:0]}. This window is mirrored in the same way as the main I/O window.
- R7: A processor address in 0x8000-0xBFFF asserts hole_flag, asserts none of mem_sel, io_main_sel or io_sec_sel, and drives bus_addr to zero.
- R8: Out of mem_sel, io_main_sel, io_sec_sel and hole_flag, exactly one is high at any time outside reset.
- R9: When reg_wr_en is high at a rising clock edge and reg_addr is 0 to 3, reg_wdata is loaded into that page register and the translation uses it from then on. A write to offsets 4 to 7 changes no page.
- R10: A synchronous active-high rst clears all four page registers to zero.
- R11: Bits 1 and 0 of the two 16 KB page registers have no effect on bus_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Page register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| cpu_addr | input | 16 | Processor address |
| bus_addr | output | 20 | Translated bus address |
| mem_sel | output | 1 | Bus memory select |
| io_main_sel | output | 1 | Main I/O window select |
| io_sec_sel | output | 1 | Secondary I/O window select |
| hole_flag | output | 1 | Access to the unused band |

## Verification
A page register holding the wrong value shows up only when the processor address falls inside that register's window. The error appears as wrong upper bus_addr bits in the same cycle, so the bench visits every window after each register write. A misdecoded region shows at once as the wrong select, or as two selects at the same time. Mirroring and low-bit faults appear as a mismatch on the passed-through bits or the forced-zero bits.

// File: rtl/aux_xlate_pkg.sv
package aux_xlate_pkg;

    localparam int CPU_AW    = 16;
    localparam int BUS_AW    = 20;
    localparam int PAGE_W    = 8;
    localparam int NUM_PAGES = 4;
    localparam int REG_AW    = 3;

    localparam int BIG_OFS   = 14;
    localparam int SMALL_OFS = 12;
    localparam int IO_OFS    = 11;

    localparam int PG_LOW16  = 0;
    localparam int PG_HIGH16 = 1;
    localparam int PG_WIN0   = 2;
    localparam int PG_WIN1   = 3;

    typedef enum logic [2:0] {
        RG_LOW16  = 3'd0,
        RG_WIN0   = 3'd1,
        RG_WIN1   = 3'd2,
        RG_IOSEC  = 3'd3,
        RG_IOMAIN = 3'd4,
        RG_HOLE   = 3'd5,
        RG_HIGH16 = 3'd6
    } region_e;

    typedef struct packed {
        logic mem;
        logic io_main;
        logic io_sec;
        logic hole;
    } sel_t;

    typedef logic [NUM_PAGES-1:0][PAGE_W-1:0] page_bank_t;

    function automatic region_e classify(input logic [CPU_AW-1:0] a);
        region_e r;
        unique case (a[CPU_AW-1 -: 4])
            4'h0, 4'h1, 4'h2, 4'h3: r = RG_LOW16;
            4'h4:                   r = RG_WIN0;
            4'h5:                   r = RG_WIN1;
            4'h6:                   r = RG_IOSEC;
            4'h7:                   r = RG_IOMAIN;
            4'h8, 4'h9, 4'hA, 4'hB: r = RG_HOLE;
            default:                r = RG_HIGH16;
        endcase
        return r;
    endfunction

    function automatic sel_t region_sel(input region_e r);
        sel_t s;
        s = '0;
        unique case (r)
            RG_IOSEC:  s.io_sec  = 1'b1;
            RG_IOMAIN: s.io_main = 1'b1;
            RG_HOLE:   s.hole    = 1'b1;
            default:   s.mem     = 1'b1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/aux_page_regs.sv
module aux_page_regs
    import aux_xlate_pkg::*;
#(
    parameter int P_PAGE_W    = PAGE_W,
    parameter int P_NUM_PAGES = NUM_PAGES,
    parameter int P_REG_AW    = REG_AW
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  wr_en,
    input  logic [P_REG_AW-1:0]                   wr_addr,
    input  logic [P_PAGE_W-1:0]                   wr_data,
    output logic [P_NUM_PAGES-1:0][P_PAGE_W-1:0]  pages
);

    for (genvar g = 0; g < P_NUM_PAGES; g++) begin : g_page
        logic hit;
        assign hit = wr_en && (wr_addr == P_REG_AW'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                pages[g] <= '0;
            end else if (hit) begin
                pages[g] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/aux_region_decode.sv
module aux_region_decode
    import aux_xlate_pkg::*;
(
    input  logic [CPU_AW-1:0] cpu_addr,
    output region_e          region,
    output sel_t             sel
);

    always_comb begin
        region = classify(cpu_addr);
        sel    = region_sel(region);
    end

endmodule

// File: rtl/aux_addr_compose.sv
module aux_addr_compose
    import aux_xlate_pkg::*;
(
    input  region_e           region,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  page_bank_t        pages,
    output logic [BUS_AW-1:0] bus_addr
);

    localparam int BIG_HI   = BUS_AW - BIG_OFS;
    localparam int SMALL_HI = BUS_AW - SMALL_OFS;

    logic [BUS_AW-1:0] big_low, big_high, win0, win1, io_addr;

    always_comb begin
        big_low  = {pages[PG_LOW16][PAGE_W-1 -: BIG_HI], cpu_addr[BIG_OFS-1:0]};
        big_high = {pages[PG_HIGH16][PAGE_W-1 -: BIG_HI], cpu_addr[BIG_OFS-1:0]};
        win0     = {pages[PG_WIN0][PAGE_W-1 -: SMALL_HI], cpu_addr[SMALL_OFS-1:0]};
        win1     = {pages[PG_WIN1][PAGE_W-1 -: SMALL_HI], cpu_addr[SMALL_OFS-1:0]};
        io_addr  = {{(BUS_AW-IO_OFS){1'b0}}, cpu_addr[IO_OFS-1:0]};
        unique case (region)
            RG_LOW16:            bus_addr = big_low;
            RG_HIGH16:           bus_addr = big_high;
            RG_WIN0:             bus_addr = win0;
            RG_WIN1:             bus_addr = win1;
            RG_IOSEC, RG_IOMAIN: bus_addr = io_addr;
            default:             bus_addr = '0;
        endcase
    end

endmodule

// File: rtl/aux_window_xlate.sv
module aux_window_xlate
    import aux_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [PAGE_W-1:0] reg_wdata,
    input  logic [CPU_AW-1:0] cpu_addr,
    output logic [BUS_AW-1:0] bus_addr,
    output logic              mem_sel,
    output logic              io_main_sel,
    output logic              io_sec_sel,
    output logic              hole_flag
);

    page_bank_t pages;
    region_e    region;
    sel_t       sel;

    aux_page_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .pages   (pages)
    );

    aux_region_decode u_dec (
        .cpu_addr (cpu_addr),
        .region   (region),
        .sel      (sel)
    );

    aux_addr_compose u_comp (
        .region   (region),
        .cpu_addr (cpu_addr),
        .pages    (pages),
        .bus_addr (bus_addr)
    );

    assign mem_sel     = sel.mem;
    assign io_main_sel = sel.io_main;
    assign io_sec_sel  = sel.io_sec;
    assign hole_flag   = sel.hole;

endmodule

// File: rtl/aux_xlate_checker.sv
module aux_xlate_checker
    import aux_xlate_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr_en,
    input logic [REG_AW-1:0] reg_addr,
    input logic [PAGE_W-1:0] reg_wdata,
    input logic [CPU_AW-1:0] cpu_addr,
    input logic [BUS_AW-1:0] bus_addr,
    input logic              mem_sel,
    input logic              io_main_sel,
    input logic              io_sec_sel,
    input logic              hole_flag
);

    a_r8_single_select: assert property (@(posedge clk) disable iff (rst)
        $countones({mem_sel, io_main_sel, io_sec_sel, hole_flag}) == 1);

    a_r7_hole_quiet: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:14] == 2'b10) |-> (hole_flag && !mem_sel && bus_addr == '0));

    a_r5_main_io_mirror: assert property (@(posedge clk) disable iff (rst)
        io_main_sel |-> (bus_addr[BUS_AW-1:IO_OFS] == '0 && bus_addr[IO_OFS-1:0] == cpu_addr[IO_OFS-1:0]));

    a_r6_sec_io_window: assert property (@(posedge clk) disable iff (rst)
        io_sec_sel |-> (cpu_addr[15:12] == 4'h6));

    a_r3_win0_write: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr == 3'd2) |=>
            (cpu_addr[15:12] != 4'h4 || bus_addr[BUS_AW-1:SMALL_OFS] == $past(reg_wdata)));

    a_r1_low_passthru: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:14] == 2'b00) |-> (mem_sel && bus_addr[BIG_OFS-1:0] == cpu_addr[BIG_OFS-1:0]));

endmodule

bind aux_window_xlate aux_xlate_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_en   (reg_wr_en),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .cpu_addr    (cpu_addr),
    .bus_addr    (bus_addr),
    .mem_sel     (mem_sel),
    .io_main_sel (io_main_sel),
    .io_sec_sel  (io_sec_sel),
    .hole_flag   (hole_flag)
);

// File: tb/aux_window_xlate_bench.sv
`timescale 1ns/1ps
module aux_window_xlate_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [15:0] cpu_addr = '0;
    logic [19:0] bus_addr;
    logic        mem_sel, io_main_sel, io_sec_sel, hole_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int model_pg [4];

    always #2.5 clk = ~clk;

    aux_window_xlate u_aux_window_xlate (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cpu_addr(cpu_addr), .bus_addr(bus_addr),
        .mem_sel(mem_sel), .io_main_sel(io_main_sel), .io_sec_sel(io_sec_sel),
        .hole_flag(hole_flag)
    );

    function automatic string tag_of(int a);
        if (a < 'h4000) return "R1";
        if (a >= 'hC000) return "R2";
        if (a < 'h5000) return "R3";
        if (a < 'h6000) return "R4";
        if (a < 'h7000) return "R6";
        if (a < 'h8000) return "R5";
        return "R7";
    endfunction

    task automatic compare(input string tag);
        int a, exp_bus;
        bit em, ei, es, eh;
        a = cpu_addr;
        em = 0; ei = 0; es = 0; eh = 0; exp_bus = 0;
        if (a < 'h4000)      begin em = 1; exp_bus = (model_pg[0] / 4) * 'h4000 + (a % 'h4000); end
        else if (a < 'h5000) begin em = 1; exp_bus = model_pg[2] * 'h1000 + (a % 'h1000); end
        else if (a < 'h6000) begin em = 1; exp_bus = model_pg[3] * 'h1000 + (a % 'h1000); end
        else if (a < 'h7000) begin es = 1; exp_bus = a % 'h800; end
        else if (a < 'h8000) begin ei = 1; exp_bus = a % 'h800; end
        else if (a < 'hC000) begin eh = 1; exp_bus = 0; end
        else                 begin em = 1; exp_bus = (model_pg[1] / 4) * 'h4000 + (a % 'h4000); end
        checks++;
        if (bus_addr !== 20'(exp_bus) || mem_sel !== em || io_main_sel !== ei ||
            io_sec_sel !== es || hole_flag !== eh) begin
            errors++;
            $display("FAIL %s R8 addr=%h actual bus=%h sel=%b%b%b%b expected bus=%h sel=%b%b%b%b",
                     tag, a[15:0], bus_addr, mem_sel, io_main_sel, io_sec_sel, hole_flag,
                     20'(exp_bus), em, ei, es, eh);
        end
    endtask

    // drive at negedge, check mid-low phase, model commits at posedge
    task automatic cyc(input bit we, input int ofs, input int data, input int addr, input string tag);
        @(negedge clk);
        reg_wr_en = we; reg_addr = 3'(ofs); reg_wdata = 8'(data); cpu_addr = 16'(addr);
        #1;
        if (!rst) compare(tag.len() ? tag : tag_of(addr));
        @(posedge clk);
        if (rst) for (int i = 0; i < 4; i++) model_pg[i] = 0;   // R10
        else if (we && ofs < 4) model_pg[ofs] = data & 'hFF;     // R9
    endtask

    initial begin
        for (int i = 0; i < 4; i++) model_pg[i] = 'h55;
        cyc(1, 0, 'hAB, 0, "");
        cyc(0, 0, 0, 0, "");
        rst = 1'b0;
        // R10 reset state: all pages zero
        cyc(0, 0, 0, 'h1234, "R10");
        cyc(0, 0, 0, 'hF00D, "R10");
        cyc(0, 0, 0, 'h4ABC, "R10");
        cyc(0, 0, 0, 'h5ABC, "R10");
        // R9 writes to each page
        cyc(1, 0, 'hFF, 'h3FFF, "R9");
        cyc(1, 1, 'h83, 'h0001, "R1");
        cyc(1, 2, 'hA5, 'hC123, "R2");
        cyc(1, 3, 'h3C, 'h4FFF, "R3");
        cyc(0, 0, 0, 'h5001, "R4");
        // R11 low page bits ignored
        cyc(1, 0, 'h7C, 'h2222, "R11");
        cyc(0, 0, 0, 'h2222, "R11");
        cyc(1, 1, 'h82, 'hFFFF, "R11");
        cyc(0, 0, 0, 'hFFFF, "R11");
        // R5 / R6 mirrors
        cyc(0, 0, 0, 'h7012, "R5");
        cyc(0, 0, 0, 'h7812, "R5");
        cyc(0, 0, 0, 'h6345, "R6");
        cyc(0, 0, 0, 'h6B45, "R6");
        // R7 hole boundaries
        cyc(0, 0, 0, 'h8000, "R7");
        cyc(0, 0, 0, 'hBFFF, "R7");
        cyc(0, 0, 0, 'h7FFF, "R5");
        cyc(0, 0, 0, 'hC000, "R2");
        // R9 offsets 4..7 ignored
        for (int o = 4; o < 8; o++) cyc(1, o, 'h11 * o, 'h4000, "R9");
        cyc(0, 0, 0, 'h4000, "R9");
        cyc(0, 0, 0, 'h5000, "R9");
        cyc(0, 0, 0, 'h0000, "R9");
        cyc(0, 0, 0, 'hE000, "R9");
        // random traffic
        for (int n = 0; n < 3000; n++)
            cyc(($urandom % 4) == 0, $urandom % 8, $urandom % 256, $urandom % 65536, "");
        // R10 reset again mid-run
        rst = 1'b1;
        cyc(0, 0, 0, 0, "");
        rst = 1'b0;
        cyc(0, 0, 0, 'h4777, "R10");
        cyc(0, 0, 0, 'hD777, "R10");
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog R8 actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule